// File: doc/BRIEF.md
# Privileged Flags Register Controller

This block owns a 32-bit legacy-mode flags register and a companion debug-disable bit. Every explicit write to the register comes with the writer's current privilege level and a writer kind: a flag-pop instruction, some other legacy-mode instruction, or a native-mode instruction. The block filters each system bit of that write by privilege and by writer kind. Writes that are not allowed are dropped without any fault. The bits that carry no system meaning take the written value on every write.

The resume flag and the debug-disable bit are also moved by events. These are instruction retirement, the end of a repeated string instruction, a jump into native mode, an interruption of a repeated string instruction, and a restore of the debug-disable bit when legacy mode is entered. When a flag-pop changes the alignment-check bit, the block raises a one-cycle intercept trap. It also drives three signals from the register state: an I/O port permission, an alignment-fault qualifier for legacy accesses, and a code-breakpoint suppress.

Top module: `sysflag_ctrl`

## Requirements
- R1: While reset is active, and right after it, the flags read 0x00000002, debug-disable reads 0 and the intercept output is 0.
- R2: The I/O privilege field (bits 13:12) and the virtual-8086 bit (bit 17) take a written value only when the privilege level is 0. At any other level they keep their old value.
- R3: The interrupt-enable bit (bit 9) takes a written value only when the privilege level is less than or equal to the current I/O privilege field, whatever the writer kind. The I/O permission output is 1 exactly under that same condition.
- R4: Writer kinds are encoded as 00 = flag-pop, 01 = other legacy, 10 = native, and 11 behaves as other legacy. The nested-task bit (bit 14) and the alignment-check bit (bit 18) are writable at every level by every kind. The intercept output is 1 in the cycle after a flag-pop write whose bit 18 differs from the stored bit 18, and it is 0 after any other write.
- R5: The resume flag (bit 16) takes a written value only from native writes, at any privilege level. Legacy writes, flag-pop included, leave it unchanged.
- R6: A retire, string-done or jump-to-native event clears both the resume flag and debug-disable on the next edge.
- R7: A string-interrupt event sets the resume flag to 1. A debug-disable restore request sets debug-disable to 1, and it stays 1 until a clear event arrives.
- R8: Clear events win over a string-interrupt or a restore request, and a string-interrupt wins over an explicit write of the resume flag.
- R9: The breakpoint-suppress output is 1 while the resume flag or debug-disable is 1.
- R10: The alignment-fault output is 1 when a legacy unaligned access is presented and either the status alignment bit is 1, or the control alignment-mask bit, bit 18 and an effective privilege of 3 all hold together.
- R11: Bit 1 always reads 1. All bits other than 1, 9, 12, 13, 16 and 17 take the written value on any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privLvl | input | PRIV_W | Current privilege level of the writer |
| wrEn | input | 1 | Explicit register write strobe |
| wrKind | input | 2 | Writer kind (00 pop, 01 legacy, 10 native) |
| wrData | input | FLAG_W | Value being written |
| retireOk | input | 1 | A legacy instruction completed successfully |
| strDone | input | 1 | Final iteration of a repeated string instruction completed |
| jumpNative | input | 1 | Switch into native mode |
| strIntr | input | 1 | Repeated string instruction interrupted before its final iteration |
| dbgDisSet | input | 1 | Restore debug-disable to 1 on entry to legacy mode |
| unalignedLegacy | input | 1 | Legacy access is unaligned |
| psrAlign | input | 1 | Status-register alignment check enable |
| crAlignMask | input | 1 | Control-register alignment mask enable |
| effPriv | input | PRIV_W | Effective privilege of the memory access |
| flags | output | FLAG_W | Flags register contents |
| dbgDis | output | 1 | Instruction-debug-disable bit |
| bkptSuppress | output | 1 | Code breakpoints suppressed |
| ioAllowed | output | 1 | Legacy I/O port access permitted |
| alignFault | output | 1 | Alignment fault qualifier |
| sysIntercept | output | 1 | One-cycle system-flag intercept trap |

## Verification
The bench builds the block with FLAG_W = 32 and PRIV_W = 2. With these values there are only four privilege levels and four I/O privilege values, so the bench can try every combination of privilege, I/O privilege and writer kind. At each point it writes a value that flips every bit, so that each gate is exercised in both directions. The two-bit effective privilege also lets the bench sweep the full input space of the alignment-fault qualifier. Directed sequences cover the event ordering of the resume flag and debug-disable, including every pair of events that can collide in one cycle.

// File: rtl/sysflag_pkg.sv
package sysflag_pkg;

  typedef enum logic [1:0] {
    KIND_POP    = 2'b00,
    KIND_LEGACY = 2'b01,
    KIND_NATIVE = 2'b10,
    KIND_RSVD   = 2'b11
  } wrKind_e;

  localparam int BIT_ONE     = 1;
  localparam int BIT_IE      = 9;
  localparam int BIT_IOPL_LO = 12;
  localparam int BIT_NT      = 14;
  localparam int BIT_RF      = 16;
  localparam int BIT_VM      = 17;
  localparam int BIT_AC      = 18;

  typedef struct packed {
    logic clrResume;
    logic setResume;
    logic wrResume;
    logic setDbgDis;
    logic wrIopl;
    logic wrVm;
    logic wrIe;
    logic wrPlain;
    logic popAcFlip;
  } strobes_t;

endpackage

// File: rtl/sysflag_ctrl_unit.sv
module sysflag_ctrl_unit
  import sysflag_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              wrEn,
  input  wrKind_e           wrKind,
  input  logic [PRIV_W-1:0] privLvl,
  input  logic [PRIV_W-1:0] curIopl,
  input  logic              curAc,
  input  logic              newAc,
  input  logic              retireOk,
  input  logic              strDone,
  input  logic              jumpNative,
  input  logic              strIntr,
  input  logic              dbgDisSet,
  output strobes_t          stb
);

  logic clrAny;
  logic privZero;

  always_comb begin
    clrAny   = retireOk | strDone | jumpNative;
    privZero = (privLvl == '0);

    // resume-flag sources in priority order: clear, set, explicit write
    stb.clrResume = clrAny;
    stb.setResume = strIntr & ~clrAny;
    stb.wrResume  = wrEn & (wrKind == KIND_NATIVE) & ~clrAny & ~strIntr;
    stb.setDbgDis = dbgDisSet & ~clrAny;

    // privilege filtering of system fields
    stb.wrIopl    = wrEn & privZero;
    stb.wrVm      = wrEn & privZero;
    stb.wrIe      = wrEn & (privLvl <= curIopl);
    stb.wrPlain   = wrEn;
    stb.popAcFlip = wrEn & (wrKind == KIND_POP) & (newAc != curAc);
  end

endmodule

// File: rtl/sysflag_regs.sv
module sysflag_regs
  import sysflag_pkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] flagsQ,
  output logic              dbgDisQ,
  output logic              trapQ
);

  localparam logic [FLAG_W-1:0] ONE       = {{(FLAG_W-1){1'b0}}, 1'b1};
  localparam logic [FLAG_W-1:0] IOPL_ONES = {{(FLAG_W-PRIV_W){1'b0}}, {PRIV_W{1'b1}}};
  localparam logic [FLAG_W-1:0] GUARDED   = (ONE << BIT_ONE) | (ONE << BIT_IE)
                                          | (IOPL_ONES << BIT_IOPL_LO)
                                          | (ONE << BIT_RF) | (ONE << BIT_VM);
  localparam logic [FLAG_W-1:0] RESET_VAL = ONE << BIT_ONE;

  logic [FLAG_W-1:0] flagsNxt;
  logic              dbgDisNxt;

  always_comb begin
    flagsNxt = flagsQ;
    if (stb.wrPlain) flagsNxt = (flagsQ & GUARDED) | (wrData & ~GUARDED);
    if (stb.wrIopl)  flagsNxt[BIT_IOPL_LO +: PRIV_W] = wrData[BIT_IOPL_LO +: PRIV_W];
    if (stb.wrVm)    flagsNxt[BIT_VM] = wrData[BIT_VM];
    if (stb.wrIe)    flagsNxt[BIT_IE] = wrData[BIT_IE];
    if (stb.clrResume)      flagsNxt[BIT_RF] = 1'b0;
    else if (stb.setResume) flagsNxt[BIT_RF] = 1'b1;
    else if (stb.wrResume)  flagsNxt[BIT_RF] = wrData[BIT_RF];
    flagsNxt[BIT_ONE] = 1'b1;

    if (stb.clrResume)      dbgDisNxt = 1'b0;
    else if (stb.setDbgDis) dbgDisNxt = 1'b1;
    else                    dbgDisNxt = dbgDisQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ  <= RESET_VAL;
      dbgDisQ <= 1'b0;
      trapQ   <= 1'b0;
    end else begin
      flagsQ  <= flagsNxt;
      dbgDisQ <= dbgDisNxt;
      trapQ   <= stb.popAcFlip;
    end
  end

endmodule

// File: rtl/sysflag_ctrl.sv
module sysflag_ctrl
  import sysflag_pkg::*;
#(
  parameter int FLAG_W = 32,
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRIV_W-1:0] privLvl,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [FLAG_W-1:0] wrData,
  input  logic              retireOk,
  input  logic              strDone,
  input  logic              jumpNative,
  input  logic              strIntr,
  input  logic              dbgDisSet,
  input  logic              unalignedLegacy,
  input  logic              psrAlign,
  input  logic              crAlignMask,
  input  logic [PRIV_W-1:0] effPriv,
  output logic [FLAG_W-1:0] flags,
  output logic              dbgDis,
  output logic              bkptSuppress,
  output logic              ioAllowed,
  output logic              alignFault,
  output logic              sysIntercept
);

  strobes_t          stb;
  logic [PRIV_W-1:0] curIopl;

  assign curIopl = flags[BIT_IOPL_LO +: PRIV_W];

  sysflag_ctrl_unit #(.PRIV_W(PRIV_W)) ctrl_i (
    .wrEn       (wrEn),
    .wrKind     (wrKind_e'(wrKind)),
    .privLvl    (privLvl),
    .curIopl    (curIopl),
    .curAc      (flags[BIT_AC]),
    .newAc      (wrData[BIT_AC]),
    .retireOk   (retireOk),
    .strDone    (strDone),
    .jumpNative (jumpNative),
    .strIntr    (strIntr),
    .dbgDisSet  (dbgDisSet),
    .stb        (stb)
  );

  sysflag_regs #(.FLAG_W(FLAG_W), .PRIV_W(PRIV_W)) regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .flagsQ  (flags),
    .dbgDisQ (dbgDis),
    .trapQ   (sysIntercept)
  );

  assign bkptSuppress = flags[BIT_RF] | dbgDis;
  assign ioAllowed    = (privLvl <= curIopl);
  assign alignFault   = unalignedLegacy &
                        (psrAlign | (crAlignMask & flags[BIT_AC] & (&effPriv)));

endmodule

// File: rtl/sysflag_ctrl_chk.sv
module sysflag_ctrl_chk #(
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PRIV_W-1:0] privLvl,
  input logic              wrEn,
  input logic [1:0]        wrKind,
  input logic              clrEvt,
  input logic              strIntr,
  input logic [PRIV_W-1:0] ioplBits,
  input logic              vmBit,
  input logic              ieBit,
  input logic              rfBit,
  input logic              dbgDis,
  input logic              sysIntercept
);

  assert_iopl_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && privLvl != '0) |=> $stable(ioplBits));

  assert_vm_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && privLvl != '0) |=> $stable(vmBit));

  assert_ie_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && privLvl > ioplBits) |=> $stable(ieBit));

  assert_no_trap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrKind != 2'b00) |=> !sysIntercept);

  assert_rf_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrKind != 2'b10 && !clrEvt && !strIntr) |=> $stable(rfBit));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrEvt |=> (!rfBit && !dbgDis));

  assert_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strIntr && !clrEvt) |=> rfBit);

endmodule

bind sysflag_ctrl sysflag_ctrl_chk #(.PRIV_W(PRIV_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .privLvl      (privLvl),
  .wrEn         (wrEn),
  .wrKind       (wrKind),
  .clrEvt       (retireOk | strDone | jumpNative),
  .strIntr      (strIntr),
  .ioplBits     (flags[sysflag_pkg::BIT_IOPL_LO +: PRIV_W]),
  .vmBit        (flags[sysflag_pkg::BIT_VM]),
  .ieBit        (flags[sysflag_pkg::BIT_IE]),
  .rfBit        (flags[sysflag_pkg::BIT_RF]),
  .dbgDis       (dbgDis),
  .sysIntercept (sysIntercept)
);

// File: tb/sysflag_ctrl_tb_top.sv
module sysflag_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  privLvl;
  logic        wrEn;
  logic [1:0]  wrKind;
  logic [31:0] wrData;
  logic        retireOk, strDone, jumpNative, strIntr, dbgDisSet;
  logic        unalignedLegacy, psrAlign, crAlignMask;
  logic [1:0]  effPriv;
  logic [31:0] flags;
  logic        dbgDis, bkptSuppress, ioAllowed, alignFault, sysIntercept;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [31:0] expFlags;
  logic        expId;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysflag_ctrl dut_i (
    .clk(clk), .rstN(rstN), .privLvl(privLvl), .wrEn(wrEn), .wrKind(wrKind),
    .wrData(wrData), .retireOk(retireOk), .strDone(strDone),
    .jumpNative(jumpNative), .strIntr(strIntr), .dbgDisSet(dbgDisSet),
    .unalignedLegacy(unalignedLegacy), .psrAlign(psrAlign),
    .crAlignMask(crAlignMask), .effPriv(effPriv), .flags(flags),
    .dbgDis(dbgDis), .bkptSuppress(bkptSuppress), .ioAllowed(ioAllowed),
    .alignFault(alignFault), .sysIntercept(sysIntercept)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Expected register after one explicit write, from R2 R3 R5 R11
  function automatic logic [31:0] model(input logic [31:0] cur, input int priv,
                                        input int kind, input logic [31:0] data);
    logic [31:0] r;
    r = (cur & 32'h0003_3202) | (data & ~32'h0003_3202);
    if (priv == 0) begin
      r[13:12] = data[13:12];
      r[17]    = data[17];
    end
    if (priv <= int'(cur[13:12])) r[9] = data[9];
    if (kind == 2) r[16] = data[16];
    r[1] = 1'b1;
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doWrite(input int priv, input int kind, input logic [31:0] data);
    privLvl = 2'(priv);
    wrKind  = 2'(kind);
    wrData  = data;
    wrEn    = 1'b1;
    expFlags = model(expFlags, priv, kind, data);
    step();
    wrEn = 1'b0;
  endtask

  task automatic idle();
    wrEn = 0; retireOk = 0; strDone = 0; jumpNative = 0; strIntr = 0; dbgDisSet = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
      summary();
    end
  end

  initial begin
    logic [31:0] old;
    bit expTrap;
    rstN = 0; privLvl = 0; wrKind = 0; wrData = 0; idle();
    unalignedLegacy = 0; psrAlign = 0; crAlignMask = 0; effPriv = 0;
    expFlags = 32'h0000_0002; expId = 0;
    repeat (3) @(negedge clk);
    chk(flags == 32'h2, "R1 reset flags", flags, 32'h2);
    chk(dbgDis == 1'b0, "R1 reset dbgDis", 32'(dbgDis), 0);
    chk(sysIntercept == 1'b0, "R1 reset intercept", 32'(sysIntercept), 0);
    rstN = 1;
    step();
    chk(flags == 32'h2, "R1 after reset", flags, 32'h2);

    // Sweep privilege x I/O privilege x writer kind
    for (int p = 0; p < 4; p++) begin
      for (int io = 0; io < 4; io++) begin
        for (int k = 0; k < 3; k++) begin
          doWrite(0, 2, 32'(io) << 12);
          chk(flags == expFlags, "R2 setup", flags, expFlags);
          privLvl = 2'(p);
          #1;
          chk(ioAllowed == (p <= io), "R3 ioAllowed", 32'(ioAllowed), 32'(p <= io));
          old = expFlags;
          expTrap = (k == 0);
          doWrite(p, k, ~old);
          chk(flags == expFlags, "R2 R3 R4 R5 R11 sweep", flags, expFlags);
          chk(sysIntercept == expTrap, "R4 intercept", 32'(sysIntercept), 32'(expTrap));
          step();
          chk(sysIntercept == 1'b0, "R4 intercept one cycle", 32'(sysIntercept), 0);
        end
      end
    end

    // Pop write touching only nested-task: no intercept
    doWrite(0, 2, 32'h0);
    doWrite(3, 0, 32'h0000_4000);
    chk(flags == expFlags && flags[14], "R4 pop nested-task", flags, expFlags);
    chk(sysIntercept == 1'b0, "R4 pop nt no trap", 32'(sysIntercept), 0);

    // Resume flag write paths
    doWrite(3, 2, 32'h0001_0000);
    chk(flags[16] == 1'b1, "R5 native rf at level 3", 32'(flags[16]), 1);
    chk(bkptSuppress == 1'b1, "R9 suppress from rf", 32'(bkptSuppress), 1);
    doWrite(0, 1, 32'h0);
    chk(flags[16] == 1'b1, "R5 legacy write keeps rf", 32'(flags[16]), 1);
    doWrite(0, 0, 32'h0);
    chk(flags[16] == 1'b1, "R5 pop keeps rf", 32'(flags[16]), 1);
    retireOk = 1; step(); idle();
    chk(flags[16] == 1'b0, "R6 retire clears rf", 32'(flags[16]), 0);
    chk(bkptSuppress == 1'b0, "R9 suppress off", 32'(bkptSuppress), 0);

    // Debug-disable restore and clear events
    dbgDisSet = 1; step(); idle();
    chk(dbgDis == 1'b1, "R7 restore sets dbgDis", 32'(dbgDis), 1);
    chk(bkptSuppress == 1'b1, "R9 suppress from dbgDis", 32'(bkptSuppress), 1);
    step();
    chk(dbgDis == 1'b1, "R7 dbgDis holds", 32'(dbgDis), 1);
    retireOk = 1; step(); idle();
    chk(dbgDis == 1'b0, "R6 retire clears dbgDis", 32'(dbgDis), 0);

    strIntr = 1; step(); idle();
    chk(flags[16] == 1'b1, "R7 string interrupt sets rf", 32'(flags[16]), 1);
    dbgDisSet = 1; step(); idle();
    strDone = 1; step(); idle();
    chk(flags[16] == 1'b0 && dbgDis == 1'b0, "R6 string done clears",
        {flags[16], dbgDis}, 0);
    strIntr = 1; dbgDisSet = 1; step(); idle();
    jumpNative = 1; step(); idle();
    chk(flags[16] == 1'b0 && dbgDis == 1'b0, "R6 jump native clears",
        {flags[16], dbgDis}, 0);

    // Priority collisions
    strIntr = 1; privLvl = 0; wrKind = 2; wrData = 32'h0; wrEn = 1;
    step(); idle();
    chk(flags[16] == 1'b1, "R8 set beats write", 32'(flags[16]), 1);
    retireOk = 1; strIntr = 1; dbgDisSet = 1; step(); idle();
    chk(flags[16] == 1'b0 && dbgDis == 1'b0, "R8 clear beats set",
        {flags[16], dbgDis}, 0);
    jumpNative = 1; wrKind = 2; wrData = 32'h0001_0000; wrEn = 1;
    step(); idle();
    chk(flags[16] == 1'b0, "R8 clear beats write", 32'(flags[16]), 0);

    // Alignment fault qualifier sweep
    for (int ac = 0; ac < 2; ac++) begin
      doWrite(0, 2, 32'(ac) << 18);
      for (int v = 0; v < 32; v++) begin
        bit expF;
        unalignedLegacy = v[0]; psrAlign = v[1]; crAlignMask = v[2];
        effPriv = 2'(v >> 3);
        #1;
        expF = v[0] && (v[1] || (v[2] && ac == 1 && (v >> 3) == 3));
        chk(alignFault == expF, "R10 align fault", 32'(alignFault), 32'(expF));
      end
    end

    summary();
  end

endmodule